// File: doc/BRIEF.md
# Bus Clock Loss Reset Generator

This block watches a bus clock from a separate, always-running reference clock and turns a missing or too-slow bus clock into a system reset. When monitoring is enabled, a counter in the reference domain measures the time since the last bus-clock rising edge. If that time exceeds a set number of reference ticks, the block pulls an open-drain reset pad low. It also asserts an internal reset output.

Once the reset has fired, it stays asserted for as long as the bus clock is stopped. It is released only after the bus clock has produced a fixed number of rising edges. A stop request that arrives while monitoring is enabled means the bus clock is about to freeze, so the block treats it as an immediate clock loss. Two sticky cause flags record whether the last monitor reset came from a timeout or from a halt. A power-on reset clears both flags.

The block reads the pad level back through a synchronizer. A low level that another device drives onto the pad therefore also raises the internal reset, while the block's own pull-down stays released.

Top module: `clkmon_reset_gen`

## Requirements
- R1: With `mon_en` low, `pad_pull_low` is never asserted and the cause flags keep their values, however long the bus clock stays stopped.
- R2: With `mon_en` high and bus-clock rising edges spaced closer than `TIMEOUT_TICKS` minus 4 reference cycles, no reset is produced.
- R3: After the bus clock stops with `mon_en` high, `pad_pull_low` is still low 22 reference cycles later and high 38 reference cycles later (for `TIMEOUT_TICKS` = 32). The same holds for a bus clock whose period exceeds `TIMEOUT_TICKS` + 4 reference cycles.
- R4: Once asserted, `pad_pull_low` stays high for as long as the bus clock is stopped. It is still high 4 reference cycles after the third bus rising edge that follows a restart. It is low 4 reference cycles after the fourth (`PULSE_BUS_CYCLES` = 4).
- R5: `sys_rst` is high whenever the block pulls the pad low. It also goes high within 4 reference cycles when `pad_in` is held low from outside; in that case `pad_pull_low` stays low and the cause flags are unchanged. `sys_rst` returns low within 5 cycles after the pad is released.
- R6: `stop_req` high while `mon_en` is high asserts `pad_pull_low` within 2 reference cycles and leaves `cause_halt` = 1 and `cause_loss` = 0.
- R7: A timeout trip leaves `cause_loss` = 1 and `cause_halt` = 0.
- R8: `rst` drives `pad_pull_low`, `sys_rst`, `cause_loss` and `cause_halt` to 0. The cause flags otherwise keep their values after the pulse ends and during external pad resets.
- R9: `stop_req` has no effect while `mon_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock; all logic runs on it |
| rst | input | 1 | Synchronous active-high power-on reset |
| bus_clk | input | 1 | Monitored bus clock, sampled as data |
| mon_en | input | 1 | Monitoring enable |
| stop_req | input | 1 | Request that halts the bus clock |
| pad_in | input | 1 | Level sensed on the reset pad (low = reset) |
| pad_pull_low | output | 1 | Open-drain pull-down enable for the reset pad |
| sys_rst | output | 1 | Internal reset, active high |
| cause_loss | output | 1 | Last monitor reset came from a timeout |
| cause_halt | output | 1 | Last monitor reset came from a stop request |

## Verification
The detector is driven by bus clocks at random periods drawn from two bands. One band sits well below the timeout and must never trip; the other sits well above it and must always trip. Together the two bands separate correct window sizing from a counter that is never cleared or never expires. A directed stop of the clock checks both ends of the trip window, and a long stopped stretch shows that the pulse is not limited in time. Restarting the clock one edge at a time shows that the release waits for exactly four edges. Stop requests with and without enable, and an externally held pad, test the cause flags and the pad read-back path apart from the timeout path.

// File: rtl/clkmon_pkg.sv
`timescale 1ns/1ps
package clkmon_pkg;
  typedef enum logic [0:0] {
    ST_WATCH = 1'b0,
    ST_HOLD  = 1'b1
  } mon_state_t;
endpackage

// File: rtl/clkmon_sync.sv
`timescale 1ns/1ps
// Multi-stage level synchronizer into the reference domain.
module clkmon_sync #(
  parameter int  STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= {STAGES{RESET_VAL}};
    else     sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/clkmon_timeout.sv
`timescale 1ns/1ps
// Counts reference ticks since the last kick; flags expiry while armed.
module clkmon_timeout #(
  parameter int TIMEOUT = 64,
  parameter int W       = $clog2(TIMEOUT + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         arm,
  input  logic         kick,
  output logic         expired,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] LAST = W'(TIMEOUT - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !arm || kick) cnt_q <= '0;
    else if (cnt_q != LAST)  cnt_q <= cnt_q + 1'b1;
  end

  assign expired = arm && !kick && (cnt_q == LAST);
  assign cnt     = cnt_q;
endmodule

// File: rtl/clkmon_hold.sv
`timescale 1ns/1ps
// Watch/hold state machine; hold ends after PULSE bus rising edges.
module clkmon_hold
  import clkmon_pkg::*;
#(
  parameter int PULSE = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       trip,
  input  logic       bus_rise,
  output mon_state_t st_q,
  output mon_state_t st_nxt
);
  localparam int CW = $clog2(PULSE + 1);
  localparam logic [CW-1:0] LAST = CW'(PULSE - 1);

  logic [CW-1:0] edge_cnt, edge_cnt_nxt;

  always_comb begin
    st_nxt       = st_q;
    edge_cnt_nxt = edge_cnt;
    case (st_q)
      ST_WATCH: begin
        edge_cnt_nxt = '0;
        if (trip) st_nxt = ST_HOLD;
      end
      ST_HOLD: begin
        if (bus_rise) begin
          if (edge_cnt == LAST) begin
            st_nxt       = ST_WATCH;
            edge_cnt_nxt = '0;
          end else begin
            edge_cnt_nxt = edge_cnt + 1'b1;
          end
        end
      end
      default: st_nxt = ST_WATCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_WATCH;
      edge_cnt <= '0;
    end else begin
      st_q     <= st_nxt;
      edge_cnt <= edge_cnt_nxt;
    end
  end
endmodule

// File: rtl/clkmon_reset_gen.sv
`timescale 1ns/1ps
module clkmon_reset_gen
  import clkmon_pkg::*;
#(
  parameter int TIMEOUT_TICKS    = 64,
  parameter int PULSE_BUS_CYCLES = 4,
  parameter int SYNC_STAGES      = 2
) (
  input  logic ref_clk,
  input  logic rst,
  input  logic bus_clk,
  input  logic mon_en,
  input  logic stop_req,
  input  logic pad_in,
  output logic pad_pull_low,
  output logic sys_rst,
  output logic cause_loss,
  output logic cause_halt
);
  localparam int TMO_W = $clog2(TIMEOUT_TICKS + 1);

  logic             bus_lvl, bus_prev, bus_rise;
  logic             pad_lvl;
  logic             arm, tmo_hit, halt_trip, loss_trip, trip;
  logic [TMO_W-1:0] tmo_cnt;
  mon_state_t       st_q, st_nxt;

  clkmon_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_bus_sync (
    .clk(ref_clk), .rst(rst), .d(bus_clk), .q(bus_lvl)
  );

  clkmon_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_pad_sync (
    .clk(ref_clk), .rst(rst), .d(pad_in), .q(pad_lvl)
  );

  always_ff @(posedge ref_clk) begin
    if (rst) bus_prev <= 1'b0;
    else     bus_prev <= bus_lvl;
  end
  assign bus_rise = bus_lvl & ~bus_prev;

  assign arm = mon_en && (st_q == ST_WATCH);

  clkmon_timeout #(.TIMEOUT(TIMEOUT_TICKS), .W(TMO_W)) u_tmo (
    .clk(ref_clk), .rst(rst), .arm(arm), .kick(bus_rise),
    .expired(tmo_hit), .cnt(tmo_cnt)
  );

  assign halt_trip = arm && stop_req;
  assign loss_trip = tmo_hit && !halt_trip;
  assign trip      = halt_trip || loss_trip;

  clkmon_hold #(.PULSE(PULSE_BUS_CYCLES)) u_hold (
    .clk(ref_clk), .rst(rst), .trip(trip), .bus_rise(bus_rise),
    .st_q(st_q), .st_nxt(st_nxt)
  );

  always_ff @(posedge ref_clk) begin
    if (rst) begin
      pad_pull_low <= 1'b0;
      sys_rst      <= 1'b0;
      cause_loss   <= 1'b0;
      cause_halt   <= 1'b0;
    end else begin
      pad_pull_low <= (st_nxt == ST_HOLD);
      sys_rst      <= (st_nxt == ST_HOLD) || !pad_lvl;
      if (trip) begin
        cause_loss <= loss_trip;
        cause_halt <= halt_trip;
      end
    end
  end
endmodule

// File: rtl/clkmon_chk.sv
`timescale 1ns/1ps
module clkmon_chk #(
  parameter int TIMEOUT = 64,
  parameter int CW      = 7
) (
  input logic          ref_clk,
  input logic          rst,
  input logic          mon_en,
  input logic          stop_req,
  input logic          pad_pull_low,
  input logic          cause_loss,
  input logic          cause_halt,
  input logic          bus_rise,
  input logic [CW-1:0] tmo_cnt
);
  // R1
  en_gate_chk: assert property (@(posedge ref_clk) disable iff (rst)
    $rose(pad_pull_low) |-> $past(mon_en));

  // R3
  tmo_bound_chk: assert property (@(posedge ref_clk) disable iff (rst)
    tmo_cnt <= CW'(TIMEOUT - 1));

  // R4
  release_edge_chk: assert property (@(posedge ref_clk) disable iff (rst)
    $fell(pad_pull_low) |-> $past(bus_rise));

  // R6
  halt_cause_chk: assert property (@(posedge ref_clk) disable iff (rst)
    $rose(cause_halt) |-> $past(stop_req) && pad_pull_low);

  // R7
  loss_cause_chk: assert property (@(posedge ref_clk) disable iff (rst)
    $rose(cause_loss) |-> pad_pull_low && !cause_halt);
endmodule

bind clkmon_reset_gen clkmon_chk #(.TIMEOUT(TIMEOUT_TICKS), .CW(TMO_W)) u_chk (
  .ref_clk(ref_clk), .rst(rst), .mon_en(mon_en), .stop_req(stop_req),
  .pad_pull_low(pad_pull_low), .cause_loss(cause_loss), .cause_halt(cause_halt),
  .bus_rise(bus_rise), .tmo_cnt(tmo_cnt)
);

// File: tb/sim_clkmon_reset_gen.sv
`timescale 1ns/1ps
module sim_clkmon_reset_gen;
  localparam int REF_P   = 10;
  localparam int TMO     = 32;
  localparam int PULSE   = 4;

  logic ref_clk = 1'b0;
  logic rst = 1'b1, bus_clk = 1'b0, mon_en = 1'b0, stop_req = 1'b0, ext_low = 1'b0;
  logic pad_in, pad_pull_low, sys_rst, cause_loss, cause_halt;
  logic bus_run = 1'b0;
  int   bus_half = 37;
  int   n_chk = 0, n_fail = 0, pad_cnt = 0;

  assign pad_in = ~(pad_pull_low | ext_low);

  clkmon_reset_gen #(.TIMEOUT_TICKS(TMO), .PULSE_BUS_CYCLES(PULSE), .SYNC_STAGES(2)) u0 (
    .ref_clk(ref_clk), .rst(rst), .bus_clk(bus_clk), .mon_en(mon_en),
    .stop_req(stop_req), .pad_in(pad_in), .pad_pull_low(pad_pull_low),
    .sys_rst(sys_rst), .cause_loss(cause_loss), .cause_halt(cause_halt)
  );

  always #(REF_P/2) ref_clk = ~ref_clk;

  initial begin
    forever begin
      #(bus_half);
      if (bus_run) bus_clk = ~bus_clk;
      else         bus_clk = 1'b0;
    end
  end

  always @(negedge ref_clk) if (pad_pull_low) pad_cnt = pad_cnt + 1;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_ref(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic bit expect_trip(input int half_ns);
    return (2 * half_ns) / REF_P > TMO + 4;
  endfunction

  task automatic por;
    @(negedge ref_clk); rst = 1'b1;
    wait_ref(3); rst = 1'b0;
  endtask

  initial begin
    #(REF_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got 0 expected 1 (run ended)");
    finish_run();
  end

  initial begin
    int base;
    void'($urandom(32'd2024));
    wait_ref(4);
    // R8 reset state
    chk("R8 pad at reset", pad_pull_low, 0);
    chk("R8 sys_rst at reset", sys_rst, 0);
    chk("R8 flags at reset", {cause_loss, cause_halt}, 0);
    rst = 1'b0;

    // R1: disabled, clock stopped long
    base = pad_cnt; wait_ref(120);
    chk("R1 no pull while disabled", pad_cnt - base, 0);
    chk("R1 flags unchanged", {cause_loss, cause_halt}, 0);

    // R9: stop request ignored when disabled
    stop_req = 1'b1; base = pad_cnt; wait_ref(20);
    chk("R9 stop ignored", pad_cnt - base, 0);
    chk("R9 halt flag clear", cause_halt, 0);
    stop_req = 1'b0;

    // R2: fast clock with monitoring on
    bus_half = 37; bus_run = 1'b1; wait_ref(5);
    mon_en = 1'b1; base = pad_cnt; wait_ref(200);
    chk("R2 no trip with fast clock", pad_cnt - base, 0);

    // R3/R7: stop the clock
    @(negedge ref_clk); bus_run = 1'b0;
    wait_ref(TMO - 10);
    chk("R3 not yet tripped", pad_pull_low, 0);
    wait_ref(16);
    chk("R3 tripped", pad_pull_low, 1);
    chk("R5 sys_rst with pull", sys_rst, 1);
    chk("R7 cause flags", {cause_loss, cause_halt}, 2'b10);

    // R4: held indefinitely, released after the fourth edge
    wait_ref(200);
    chk("R4 held while stopped", pad_pull_low, 1);
    bus_run = 1'b1;
    repeat (PULSE - 1) @(posedge bus_clk);
    wait_ref(4);
    chk("R4 held after third edge", pad_pull_low, 1);
    @(posedge bus_clk);
    wait_ref(4);
    chk("R4 released after fourth edge", pad_pull_low, 0);
    wait_ref(5);
    chk("R5 sys_rst released", sys_rst, 0);
    chk("R8 loss flag persists", {cause_loss, cause_halt}, 2'b10);

    // R6: stop request with monitoring on
    wait_ref(20);
    @(negedge ref_clk); bus_run = 1'b0; stop_req = 1'b1;
    wait_ref(2);
    chk("R6 pull on stop", pad_pull_low, 1);
    chk("R6 cause flags", {cause_loss, cause_halt}, 2'b01);
    stop_req = 1'b0; bus_run = 1'b1; wait_ref(100);
    chk("R6 released after restart", pad_pull_low, 0);

    // R5: external pad low
    base = pad_cnt; ext_low = 1'b1; wait_ref(4);
    chk("R5 sys_rst from pad", sys_rst, 1);
    wait_ref(16);
    chk("R5 no own pull", pad_cnt - base, 0);
    chk("R5 flags unchanged", {cause_loss, cause_halt}, 2'b01);
    ext_low = 1'b0; wait_ref(5);
    chk("R5 sys_rst drops", sys_rst, 0);

    // R8: power-on reset clears flags
    por(); wait_ref(1);
    chk("R8 flags cleared", {cause_loss, cause_halt}, 0);

    // R2/R3: random bus periods from safe and slow bands
    for (int t = 0; t < 12; t++) begin
      int h; bit exp_t;
      mon_en = 1'b0; bus_half = 37; bus_run = 1'b1; wait_ref(100);
      por();
      h = ($urandom_range(0, 1) == 0) ? $urandom_range(20, 120) : $urandom_range(300, 450);
      exp_t = expect_trip(h);
      bus_half = h; wait_ref(2 * h / REF_P + 5);
      mon_en = 1'b1; base = pad_cnt; wait_ref(300);
      chk(exp_t ? "R3 random slow trips" : "R2 random fast quiet",
          (pad_cnt - base) > 0, exp_t);
      chk("R7 random loss flag", cause_loss, exp_t);
    end

    finish_run();
  end
endmodule